// File: doc/BRIEF.md
# NAND Program/Erase Sequencer

This engine sits on the host side of an 8-bit multiplexed NAND bus and runs one page-program or one block-erase transaction per request. A request names the operation and a row (block and page). A program request also gives a start column and a byte count. For a program, the engine drives the load opcode, the column byte and two row bytes. It then streams the data bytes from a byte-valid input and issues the program confirm. For an erase, it drives the setup opcode and the two row bytes, with the page bits forced to zero, followed by the execute opcode.

After the confirm, the engine issues the status opcode and keeps reading the status byte until the ready bit is set. It then grades the outcome. A cleared write-protect bit yields a protect error, a set error bit yields a failure, and anything else is success. A failure pulses a replace-block flag together with the failing block number. The engine also remembers that block and refuses all later work on it.

Every strobe width is derived from nanosecond parameters and the clock period, rounding up. A small tag table counts partial programs per page. It refuses a page that has already taken its limit, and entries for a block are cleared by a successful erase of that block.

States and transitions. `SQ_IDLE` goes to `SQ_CHECK` when a request arrives. `SQ_CHECK` goes to `SQ_FIN` with a reject code, or to `SQ_CMD`. `SQ_CMD` goes to `SQ_ADDR`. `SQ_ADDR` loops over its bytes and then goes to `SQ_DATA` for a program or to `SQ_CONF` for an erase. `SQ_DATA` loops once per byte and then goes to `SQ_CONF`. `SQ_CONF` goes to `SQ_STCMD`, which goes to `SQ_POLL`. `SQ_POLL` loops while the device is busy and goes to `SQ_FIN` once it is ready. `SQ_FIN` goes back to `SQ_IDLE`.

Top module: `nand_pe_seq`

## Requirements
- R1: After reset the bus is quiet: `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_dq_oe`=0, `busy`=0, `done`=0.
- R2: A program request produces these write cycles in order:
  - 80h with CLE high;
  - with ALE high: the column byte, row bits 7:0, then row bits 13:8 zero-extended;
  - `req_len` data bytes with CLE and ALE low;
  - 10h with CLE high, then 70h with CLE high.
- R3: An erase request produces these write cycles in order:
  - 60h with CLE high;
  - with ALE high: two row bytes, low then high, of the row with its 4 page bits cleared;
  - D0h with CLE high, then 70h with CLE high.
- R4: Each write strobe keeps WE low for at least ceil(max(tWP,tDS)/Tclk) cycles (3 at defaults). Data is driven and stable across the rising edge. Rising edges are at least ceil(tWC/Tclk) cycles apart (5 at defaults).
- R5: After 70h the engine reads status with RE strobes, repeating while bit 6 reads 0 and stopping at the first read with bit 6 = 1.
- R6: The result code is graded from the final status byte:
  - if bit 7 = 0, `res_code` is 2 (protected);
  - otherwise, if bit 0 = 1, `res_code` is 1 (failed);
  - otherwise `res_code` is 0 (ok).
- R7: A failed result (code 1) pulses `repl_flag` with `done`, and `repl_block` carries row bits 13:4 of the request. Codes other than 1 leave `repl_flag` low.
- R8: Once a block has failed, any later program or erase request to it completes with code 4 and produces no bus cycle.
- R9: A program with `req_len` of 0 or above 528 completes with code 5 and produces no bus cycle, so 10h is never sent without data.
- R10: The eleventh program to the same row completes with code 3 and produces no bus cycle. A successful erase of that row's block restores acceptance.
- R11: When all tag-table entries (8 at defaults) hold other rows, a program to an untracked row completes with code 6 and produces no bus cycle. Tracked rows still program.
- R12: `din_take` pulses exactly once per data byte. While `din_valid` is low during the data phase, no write strobe occurs.
- R13: CLE and ALE change only while WE is high. During command cycles CLE=1 and ALE=0. During address cycles ALE=1 and CLE=0. During data cycles both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_erase | input | 1 | 1 = block erase, 0 = page program |
| req_row | input | ROW_AW | Row address: block in upper bits, page in low 4 bits |
| req_col | input | 8 | Program start column byte |
| req_len | input | LEN_W | Program byte count |
| busy | output | 1 | A transaction is in progress |
| din_valid | input | 1 | Program data byte is valid |
| din_data | input | 8 | Program data byte |
| din_take | output | 1 | Current data byte is consumed this cycle |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data from the device |
| done | output | 1 | One-cycle completion pulse |
| res_code | output | 3 | 0 ok, 1 failed, 2 protected, 3 page limit, 4 bad block, 5 bad length, 6 table full |
| repl_flag | output | 1 | Block must be replaced (with `done`) |
| repl_block | output | ROW_AW-4 | Failing block number |

## Verification
Programs are driven with different lengths, columns and rows. Some have the data source stalled, which separates strobe pacing from data-flow pacing. Erases are driven with a nonzero page field to show that the page bits are dropped. The scripted device answers with zero or several busy polls, and then with pass, fail or write-protect bytes; this separates polling from grading. Requests with bad length, to a failed block, over the page limit and into a full table must each give their own code with an empty bus log.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;

    typedef enum logic [2:0] {
        RC_OK     = 3'd0,
        RC_FAIL   = 3'd1,
        RC_WPROT  = 3'd2,
        RC_LIMIT  = 3'd3,
        RC_BADBLK = 3'd4,
        RC_ARG    = 3'd5,
        RC_FULL   = 3'd6
    } res_code_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_CHECK,
        SQ_CMD,
        SQ_ADDR,
        SQ_DATA,
        SQ_CONF,
        SQ_STCMD,
        SQ_POLL,
        SQ_FIN
    } seq_state_e;

    localparam logic [7:0] OPC_LOAD   = 8'h80;
    localparam logic [7:0] OPC_PROG   = 8'h10;
    localparam logic [7:0] OPC_ESETUP = 8'h60;
    localparam logic [7:0] OPC_ERUN   = 8'hD0;
    localparam logic [7:0] OPC_STAT   = 8'h70;

    localparam int ST_ERR = 0;
    localparam int ST_RDY = 6;
    localparam int ST_NWP = 7;

    function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_pe_strobe.sv
module nand_pe_strobe #(
    parameter int unsigned WLO  = 3,
    parameter int unsigned WHI  = 2,
    parameter int unsigned RGAP = 6,
    parameter int unsigned RLO  = 5,
    parameter int unsigned RHI  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       rd,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_in,
    output logic       idle,
    output logic       fin,
    output logic       we_n,
    output logic       re_n,
    output logic       dq_oe,
    output logic [7:0] dq_out,
    output logic [7:0] rbyte
);
    localparam int unsigned CMAX = (WLO > WHI ? WLO : WHI) > (RGAP > RLO ? (RGAP > RHI ? RGAP : RHI) : (RLO > RHI ? RLO : RHI))
                                 ? (WLO > WHI ? WLO : WHI)
                                 : (RGAP > RLO ? (RGAP > RHI ? RGAP : RHI) : (RLO > RHI ? RLO : RHI));
    localparam int CW = $clog2(CMAX) + 1;

    typedef enum logic [2:0] {PH_IDLE, PH_WLO, PH_WHI, PH_RGAP, PH_RLO, PH_RHI} ph_e;

    ph_e            ph_q, ph_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [7:0]     wb_q, rb_q;
    logic           last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            wb_q  <= '0;
            rb_q  <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            if (ph_q == PH_IDLE && go && !rd)
                wb_q <= wbyte;
            if (ph_q == PH_RLO && last)
                rb_q <= dq_in;
        end
    end

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        unique case (ph_q)
            PH_IDLE: begin
                if (go) begin
                    ph_d  = rd ? PH_RGAP : PH_WLO;
                    cnt_d = rd ? CW'(RGAP - 1) : CW'(WLO - 1);
                end
            end
            PH_WLO: begin
                if (last) begin ph_d = PH_WHI; cnt_d = CW'(WHI - 1); end
                else cnt_d = cnt_q - 1'b1;
            end
            PH_WHI: begin
                if (last) ph_d = PH_IDLE;
                else cnt_d = cnt_q - 1'b1;
            end
            PH_RGAP: begin
                if (last) begin ph_d = PH_RLO; cnt_d = CW'(RLO - 1); end
                else cnt_d = cnt_q - 1'b1;
            end
            PH_RLO: begin
                if (last) begin ph_d = PH_RHI; cnt_d = CW'(RHI - 1); end
                else cnt_d = cnt_q - 1'b1;
            end
            PH_RHI: begin
                if (last) ph_d = PH_IDLE;
                else cnt_d = cnt_q - 1'b1;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    assign idle   = (ph_q == PH_IDLE);
    assign fin    = last && (ph_q == PH_WHI || ph_q == PH_RHI);
    assign we_n   = (ph_q != PH_WLO);
    assign re_n   = (ph_q != PH_RLO);
    assign dq_oe  = (ph_q == PH_WLO || ph_q == PH_WHI);
    assign dq_out = wb_q;
    assign rbyte  = rb_q;

    // R4
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (dq_oe && $stable(dq_out)));

endmodule

// File: rtl/nand_pe_ppc_tbl.sv
module nand_pe_ppc_tbl #(
    parameter int ROW_AW  = 14,
    parameter int PG_AW   = 4,
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ROW_AW-1:0]       q_row,
    input  logic                    bump,
    input  logic                    clr_en,
    input  logic [ROW_AW-PG_AW-1:0] clr_blk,
    output logic                    hit,
    output logic [CNT_W-1:0]        hit_cnt,
    output logic                    has_free
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [ROW_AW-1:0]  row_q [ENTRIES];
    logic [CNT_W-1:0]   cnt_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec, free_vec, clr_vec;
    logic [IW-1:0]      hit_idx, free_idx;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign hit_vec[i]  = vld_q[i] && (row_q[i] == q_row);
        assign free_vec[i] = !vld_q[i];
        assign clr_vec[i]  = vld_q[i] && (row_q[i][ROW_AW-1:PG_AW] == clr_blk);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                row_q[i] <= '0;
                cnt_q[i] <= '0;
            end else if (clr_en && clr_vec[i]) begin
                vld_q[i] <= 1'b0;
            end else if (bump) begin
                if (hit && hit_idx == IW'(i)) begin
                    cnt_q[i] <= cnt_q[i] + 1'b1;
                end else if (!hit && has_free && free_idx == IW'(i)) begin
                    vld_q[i] <= 1'b1;
                    row_q[i] <= q_row;
                    cnt_q[i] <= CNT_W'(1);
                end
            end
        end
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (hit_vec[k])  hit_idx  = IW'(k);
            if (free_vec[k]) free_idx = IW'(k);
        end
    end

    assign hit      = |hit_vec;
    assign has_free = |free_vec;
    assign hit_cnt  = cnt_q[hit_idx];

    // R11
    bump_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> (hit || has_free));

    // R10
    bump_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !clr_en) |=> hit);

endmodule

// File: rtl/nand_pe_badmap.sv
module nand_pe_badmap #(
    parameter int BLK_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_AW-1:0] q_blk,
    output logic              is_bad,
    input  logic              mark,
    input  logic [BLK_AW-1:0] mark_blk
);
    localparam int BLK_N = 1 << BLK_AW;

    logic [BLK_N-1:0] bad_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bad_q <= '0;
        else if (mark)
            bad_q[mark_blk] <= 1'b1;
    end

    assign is_bad = bad_q[q_blk];

    // R8
    mark_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark && mark_blk == q_blk) |=> is_bad);

endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq
    import nand_pe_pkg::*;
#(
    parameter int unsigned CLK_PS     = 10000,
    parameter int unsigned T_WC_PS    = 50000,
    parameter int unsigned T_WP_PS    = 25000,
    parameter int unsigned T_WH_PS    = 15000,
    parameter int unsigned T_DS_PS    = 20000,
    parameter int unsigned T_DH_PS    = 10000,
    parameter int unsigned T_REA_PS   = 35000,
    parameter int unsigned T_REH_PS   = 15000,
    parameter int unsigned T_WHR_PS   = 60000,
    parameter int          ROW_AW     = 14,
    parameter int          PG_AW      = 4,
    parameter int          PAGE_BYTES = 528,
    parameter int          PP_MAX     = 10,
    parameter int          TBL_N      = 8,
    localparam int         BLK_AW     = ROW_AW - PG_AW,
    localparam int         LEN_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ROW_AW-1:0] req_row,
    input  logic [7:0]        req_col,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    input  logic              din_valid,
    input  logic [7:0]        din_data,
    output logic              din_take,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    output logic              done,
    output logic [2:0]        res_code,
    output logic              repl_flag,
    output logic [BLK_AW-1:0] repl_block
);
    localparam int unsigned WLO_C  = umax(cdiv(T_WP_PS, CLK_PS), cdiv(T_DS_PS, CLK_PS));
    localparam int unsigned WHI_B  = umax(cdiv(T_WH_PS, CLK_PS), cdiv(T_DH_PS, CLK_PS));
    localparam int unsigned WC_C   = cdiv(T_WC_PS, CLK_PS);
    localparam int unsigned WHI_C  = (WLO_C + WHI_B + 1 >= WC_C) ? WHI_B : WC_C - WLO_C - 1;
    localparam int unsigned RGAP_C = cdiv(T_WHR_PS, CLK_PS);
    localparam int unsigned RLO_C  = cdiv(T_REA_PS, CLK_PS) + 1;
    localparam int unsigned RHI_C  = cdiv(T_REH_PS, CLK_PS);
    localparam int          CNT_W  = $clog2(PP_MAX + 1);

    seq_state_e         st_q, st_d;
    res_code_e          code_q, code_d;
    logic [1:0]         aidx_q, aidx_d;
    logic [LEN_W-1:0]   left_q, left_d;
    logic               erase_q, data_seen_q;
    logic [ROW_AW-1:0]  row_q;
    logic [7:0]         col_q;

    logic               stb_go, stb_rd, stb_idle, stb_fin;
    logic [7:0]         stb_wbyte, stb_rbyte;
    logic               pp_hit, pp_free, bump, blk_bad, mark, clr_en, len_bad;
    logic [CNT_W-1:0]   pp_cnt;
    logic [ROW_AW-1:0]  arow;
    logic [1:0]         addr_last, aslot;

    nand_pe_strobe #(
        .WLO(WLO_C), .WHI(WHI_C), .RGAP(RGAP_C), .RLO(RLO_C), .RHI(RHI_C)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .go(stb_go), .rd(stb_rd), .wbyte(stb_wbyte),
        .dq_in(nand_dq_in), .idle(stb_idle), .fin(stb_fin), .we_n(nand_we_n),
        .re_n(nand_re_n), .dq_oe(nand_dq_oe), .dq_out(nand_dq_out), .rbyte(stb_rbyte)
    );

    nand_pe_ppc_tbl #(
        .ROW_AW(ROW_AW), .PG_AW(PG_AW), .ENTRIES(TBL_N), .CNT_W(CNT_W)
    ) u_tbl (
        .clk(clk), .rst_n(rst_n), .q_row(row_q), .bump(bump), .clr_en(clr_en),
        .clr_blk(row_q[ROW_AW-1:PG_AW]), .hit(pp_hit), .hit_cnt(pp_cnt), .has_free(pp_free)
    );

    nand_pe_badmap #(
        .BLK_AW(BLK_AW)
    ) u_bad (
        .clk(clk), .rst_n(rst_n), .q_blk(row_q[ROW_AW-1:PG_AW]), .is_bad(blk_bad),
        .mark(mark), .mark_blk(row_q[ROW_AW-1:PG_AW])
    );

    assign len_bad   = (left_q == '0) || (left_q > LEN_W'(PAGE_BYTES));
    assign addr_last = erase_q ? 2'd1 : 2'd2;
    assign arow      = erase_q ? {row_q[ROW_AW-1:PG_AW], {PG_AW{1'b0}}} : row_q;
    assign aslot     = erase_q ? aidx_q + 2'd1 : aidx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= SQ_IDLE;
            code_q      <= RC_OK;
            aidx_q      <= '0;
            left_q      <= '0;
            erase_q     <= 1'b0;
            row_q       <= '0;
            col_q       <= '0;
            data_seen_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
            aidx_q <= aidx_d;
            left_q <= left_d;
            if (st_q == SQ_IDLE && req_valid) begin
                erase_q <= req_erase;
                row_q   <= req_row;
                col_q   <= req_col;
            end
            if (st_q == SQ_CHECK)
                data_seen_q <= 1'b0;
            else if (st_q == SQ_DATA && stb_fin)
                data_seen_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        aidx_d = aidx_q;
        left_d = left_q;
        bump   = 1'b0;
        unique case (st_q)
            SQ_IDLE: begin
                if (req_valid) begin
                    st_d   = SQ_CHECK;
                    left_d = req_len;
                end
            end
            SQ_CHECK: begin
                if (blk_bad) begin
                    code_d = RC_BADBLK; st_d = SQ_FIN;
                end else if (erase_q) begin
                    st_d = SQ_CMD;
                end else if (len_bad) begin
                    code_d = RC_ARG; st_d = SQ_FIN;
                end else if (pp_hit && pp_cnt >= CNT_W'(PP_MAX)) begin
                    code_d = RC_LIMIT; st_d = SQ_FIN;
                end else if (!pp_hit && !pp_free) begin
                    code_d = RC_FULL; st_d = SQ_FIN;
                end else begin
                    bump = 1'b1; st_d = SQ_CMD;
                end
            end
            SQ_CMD: begin
                if (stb_fin) begin st_d = SQ_ADDR; aidx_d = '0; end
            end
            SQ_ADDR: begin
                if (stb_fin) begin
                    if (aidx_q == addr_last) st_d = erase_q ? SQ_CONF : SQ_DATA;
                    else aidx_d = aidx_q + 2'd1;
                end
            end
            SQ_DATA: begin
                if (stb_fin) begin
                    left_d = left_q - 1'b1;
                    if (left_q == LEN_W'(1)) st_d = SQ_CONF;
                end
            end
            SQ_CONF: begin
                if (stb_fin) st_d = SQ_STCMD;
            end
            SQ_STCMD: begin
                if (stb_fin) st_d = SQ_POLL;
            end
            SQ_POLL: begin
                if (stb_fin && stb_rbyte[ST_RDY]) begin
                    st_d = SQ_FIN;
                    if (!stb_rbyte[ST_NWP])     code_d = RC_WPROT;
                    else if (stb_rbyte[ST_ERR]) code_d = RC_FAIL;
                    else                        code_d = RC_OK;
                end
            end
            SQ_FIN: st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        nand_cle  = 1'b0;
        nand_ale  = 1'b0;
        stb_go    = 1'b0;
        stb_rd    = 1'b0;
        stb_wbyte = 8'h00;
        din_take  = 1'b0;
        unique case (st_q)
            SQ_CMD: begin
                nand_cle  = 1'b1;
                stb_go    = stb_idle;
                stb_wbyte = erase_q ? OPC_ESETUP : OPC_LOAD;
            end
            SQ_ADDR: begin
                nand_ale = 1'b1;
                stb_go   = stb_idle;
                unique case (aslot)
                    2'd0:    stb_wbyte = col_q;
                    2'd1:    stb_wbyte = arow[7:0];
                    default: stb_wbyte = 8'(arow >> 8);
                endcase
            end
            SQ_DATA: begin
                stb_go    = stb_idle && din_valid;
                din_take  = stb_idle && din_valid;
                stb_wbyte = din_data;
            end
            SQ_CONF: begin
                nand_cle  = 1'b1;
                stb_go    = stb_idle;
                stb_wbyte = erase_q ? OPC_ERUN : OPC_PROG;
            end
            SQ_STCMD: begin
                nand_cle  = 1'b1;
                stb_go    = stb_idle;
                stb_wbyte = OPC_STAT;
            end
            SQ_POLL: begin
                stb_go = stb_idle;
                stb_rd = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy       = (st_q != SQ_IDLE);
    assign done       = (st_q == SQ_FIN);
    assign res_code   = code_q;
    assign repl_flag  = done && (code_q == RC_FAIL);
    assign repl_block = row_q[ROW_AW-1:PG_AW];
    assign mark       = done && (code_q == RC_FAIL);
    assign clr_en     = done && (code_q == RC_OK) && erase_q;

    // R13
    ctl_change_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({nand_cle, nand_ale}) |-> nand_we_n);

    // R9
    conf_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_CONF && !erase_q) |-> data_seen_q);

    // R4
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_go |-> stb_idle);

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/nand_pe_seq_tb_top.sv
module nand_pe_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_erase = 1'b0;
    logic [13:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [9:0]  req_len = '0;
    logic        busy, din_valid, din_take;
    logic [7:0]  din_data;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'h00;
    logic        done, repl_flag;
    logic [2:0]  res_code;
    logic [9:0]  repl_block;

    int total = 0, bad = 0;
    logic [9:0]  exp_bus[$];
    logic [13:0] exp_res[$];
    logic [7:0]  data_q[$];
    int  busy_left = 0, reads = 0, takes = 0, stall = 0;
    logic [7:0] fin_stat = 8'hC0;
    bit  take_pend = 0, prev_we = 1, prev_re = 1;
    int  lo_cnt = 0, since_rise = 100;

    always #5 clk = ~clk;

    nand_pe_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_row(req_row), .req_col(req_col), .req_len(req_len), .busy(busy),
        .din_valid(din_valid), .din_data(din_data), .din_take(din_take),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .done(done), .res_code(res_code),
        .repl_flag(repl_flag), .repl_block(repl_block)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: bus log, status device model, data feed, results
    always @(negedge clk) begin
        bit t;
        t = din_take;
        if (t) takes++;
        if (take_pend && data_q.size() > 0) void'(data_q.pop_front());
        take_pend = t;
        if (stall > 0) begin
            stall--;
            din_valid = 1'b0;
        end else begin
            din_valid = (data_q.size() > 0);
        end
        din_data = (data_q.size() > 0) ? data_q[0] : 8'h00;

        since_rise++;
        if (!nand_we_n) lo_cnt++;
        if (!prev_we && nand_we_n) begin
            logic [9:0] got;
            got = {nand_cle, nand_ale, nand_dq_out};
            check(lo_cnt >= 3 && nand_dq_oe, "R4 we low width", lo_cnt, 3);
            check(since_rise >= 5, "R4 write period", since_rise, 5);
            if (exp_bus.size() == 0)
                check(1'b0, "R2/R3/R13 unexpected bus cycle", got, 0);
            else begin
                logic [9:0] e;
                e = exp_bus.pop_front();
                check(got == e, "R2/R3/R13 bus cycle", got, e);
            end
            lo_cnt = 0;
            since_rise = 0;
        end
        prev_we = nand_we_n;

        if (prev_re && !nand_re_n) begin
            reads++;
            if (busy_left > 0) begin
                nand_dq_in = 8'h80;
                busy_left--;
            end else begin
                nand_dq_in = fin_stat;
            end
        end
        prev_re = nand_re_n;

        if (done) begin
            if (exp_res.size() == 0)
                check(1'b0, "R6 unexpected result", res_code, 0);
            else begin
                logic [13:0] e;
                e = exp_res.pop_front();
                check(res_code == e[13:11], "R6/R8/R9/R10/R11 result code", res_code, e[13:11]);
                check(repl_flag == e[10], "R7 replace flag", repl_flag, e[10]);
                if (e[10]) check(repl_block == e[9:0], "R7 replace block", repl_block, e[9:0]);
            end
        end
    end

    task automatic exp_prog(input logic [13:0] row, input logic [7:0] col, input int len);
        exp_bus.push_back({2'b10, 8'h80});
        exp_bus.push_back({2'b01, col});
        exp_bus.push_back({2'b01, row[7:0]});
        exp_bus.push_back({2'b01, 2'b00, row[13:8]});
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(row[7:0] + 8'(i * 7));
            exp_bus.push_back({2'b00, b});
            data_q.push_back(b);
        end
        exp_bus.push_back({2'b10, 8'h10});
        exp_bus.push_back({2'b10, 8'h70});
    endtask

    task automatic exp_erase(input logic [13:0] row);
        logic [13:0] r;
        r = {row[13:4], 4'h0};
        exp_bus.push_back({2'b10, 8'h60});
        exp_bus.push_back({2'b01, r[7:0]});
        exp_bus.push_back({2'b01, 2'b00, r[13:8]});
        exp_bus.push_back({2'b10, 8'hD0});
        exp_bus.push_back({2'b10, 8'h70});
    endtask

    task automatic issue(input bit er, input logic [13:0] row, input logic [7:0] col,
                         input logic [9:0] len, input int polls, input logic [7:0] st,
                         input logic [2:0] code, input string tag, input int exp_takes);
        busy_left = polls;
        fin_stat  = st;
        reads = 0;
        takes = 0;
        exp_res.push_back({code, code == 3'd1, row[13:4]});
        @(negedge clk);
        req_valid = 1'b1; req_erase = er; req_row = row; req_col = col; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(exp_bus.size() == 0, {tag, " bus log drained"}, exp_bus.size(), 0);
        check(takes == exp_takes, {tag, " R12 take count"}, takes, exp_takes);
        if (code <= 3'd2)
            check(reads == polls + 1, {tag, " R5 status reads"}, reads, polls + 1);
        else
            check(reads == 0, {tag, " R5 no status reads on reject"}, reads, 0);
        exp_bus.delete();
        data_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        din_valid = 1'b0;
        din_data  = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, busy, done} == 7'b1100000,
              "R1 reset state", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, busy, done}, 7'b1100000);

        // R2 program, two busy polls, pass
        exp_prog(14'h0123, 8'h05, 4);
        issue(0, 14'h0123, 8'h05, 10'd4, 2, 8'hC0, 3'd0, "R2 prog", 4);

        // R12 program with stalled data source
        stall = 7;
        exp_prog(14'h0200, 8'h00, 2);
        issue(0, 14'h0200, 8'h00, 10'd2, 0, 8'hC0, 3'd0, "R12 stalled prog", 2);

        // R3 erase with nonzero page bits dropped
        exp_erase(14'h012F);
        issue(1, 14'h012F, 8'h00, 10'd0, 1, 8'hC0, 3'd0, "R3 erase", 0);

        // R6 R7 program failure, block flagged
        exp_prog(14'h0345, 8'h10, 3);
        issue(0, 14'h0345, 8'h10, 10'd3, 3, 8'hC1, 3'd1, "R7 prog fail", 3);

        // R8 failed block refused for program and erase
        issue(0, 14'h0340, 8'h00, 10'd1, 0, 8'hC0, 3'd4, "R8 prog bad block", 0);
        issue(1, 14'h0349, 8'h00, 10'd0, 0, 8'hC0, 3'd4, "R8 erase bad block", 0);

        // R6 write-protected erase
        exp_erase(14'h0600);
        issue(1, 14'h0600, 8'h00, 10'd0, 0, 8'h41, 3'd2, "R6 protect", 0);

        // R9 bad lengths
        issue(0, 14'h0700, 8'h00, 10'd0, 0, 8'hC0, 3'd5, "R9 zero length", 0);
        issue(0, 14'h0700, 8'h00, 10'd529, 0, 8'hC0, 3'd5, "R9 long length", 0);

        // R2 full page length
        exp_prog(14'h0710, 8'h00, 528);
        issue(0, 14'h0710, 8'h00, 10'd528, 0, 8'hC0, 3'd0, "R2 full page", 528);

        // R10 partial program limit
        for (int n = 0; n < 10; n++) begin
            exp_prog(14'h03A1, 8'(n * 16), 1);
            issue(0, 14'h03A1, 8'(n * 16), 10'd1, 0, 8'hC0, 3'd0, "R10 partial", 1);
        end
        issue(0, 14'h03A1, 8'hF0, 10'd1, 0, 8'hC0, 3'd3, "R10 eleventh", 0);
        exp_erase(14'h03A0);
        issue(1, 14'h03A0, 8'h00, 10'd0, 0, 8'hC0, 3'd0, "R10 erase", 0);
        exp_prog(14'h03A1, 8'h00, 1);
        issue(0, 14'h03A1, 8'h00, 10'd1, 0, 8'hC0, 3'd0, "R10 after erase", 1);

        // R11 table full: tracked rows 0x200, 0x345, 0x710, 0x3A1 plus four more
        for (int n = 0; n < 4; n++) begin
            exp_prog(14'(14'h0500 + n * 16), 8'h00, 1);
            issue(0, 14'(14'h0500 + n * 16), 8'h00, 10'd1, 0, 8'hC0, 3'd0, "R11 fill", 1);
        end
        issue(0, 14'h0550, 8'h00, 10'd1, 0, 8'hC0, 3'd6, "R11 full", 0);
        exp_prog(14'h0500, 8'h40, 1);
        issue(0, 14'h0500, 8'h40, 10'd1, 0, 8'hC0, 3'd0, "R11 tracked ok", 1);

        check(exp_res.size() == 0, "R6 all results seen", exp_res.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule